// File: doc/BRIEF.md
# Synchronous Modulo Counter with Toggle-Enable Stages

This block is an up-counter in which every bit is its own toggle-enable stage: a D register whose next value is its current value XOR its toggle enable. Bit 0's enable is the count enable. Each higher bit's enable is the AND of the count enable and every bit below it, so a bit flips only when a carry would reach it. All stages share one clock edge. Because of this, a change such as 0111 to 1000 happens in a single step and the output never shows an intermediate value.

A terminal-value detector compares the registered count with a programmable terminal value. While they are equal and counting is enabled, it raises a synchronous clear. On the next active edge, the clear overrides the toggle/hold action in every stage and loads zero. As a result, the count never shows the value one past the terminal. Tying the terminal input to nine gives a decade sequence 0..9. The detector output is also available as a terminal flag, which a following stage can use as its count enable. The active-low asynchronous reset is used only for power-on initialisation.

Top module: `tcnt_modulo_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 immediately, without waiting for a clock edge.
- R2: On each rising edge with `cnt_en` high and `count` not equal to `term_val`, `count` increases by exactly 1.
- R3: On a rising edge with `cnt_en` high and `count` equal to `term_val`, `count` becomes 0. With `term_val` = 9, the sequence is 0..9 and the value 10 never appears.
- R4: With `cnt_en` low, `count` holds on every edge, including when it equals `term_val`, and `term_hit` stays low.
- R5: `term_hit` is 1 exactly when `count` equals `term_val` and `cnt_en` is 1. It is a decode of registered state and current inputs, and it stays level for a whole clock period.
- R6: The terminal value follows `term_val` at run time. For any setting T, the counter cycles 0..T.
- R7: If `term_val` is set below the current count, the counter counts up to all ones, wraps naturally to 0, and then follows the new terminal value.
- R8: A bit changes only when all lower bits are 1 or a clear is applied. The step from 0111 to 1000 therefore happens in one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages, rising edge active |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cnt_en | input | 1 | Count enable; gates every toggle enable and the clear |
| term_val | input | WIDTH | Terminal value at which the count wraps to zero |
| count | output | WIDTH | Registered count value |
| term_hit | output | 1 | High while count equals term_val and cnt_en is high |

## Verification
The hardest case to reach is a terminal value lowered below the current count. It needs the counter parked at a high value under one setting, and then the setting changed mid-run so that the count must climb through all ones and wrap without a clear. The stimulus first programs the terminal to fifteen and runs to twelve, then drops the terminal to five and follows the natural wrap. It also freezes the enable exactly on the terminal value, to show that a pending clear is withheld.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

  localparam int unsigned TCNT_MAX_W = 16;

  // Terminal decode used by the detector; the bench restates it independently.
  function automatic logic tcnt_term_match(input logic [TCNT_MAX_W-1:0] cur,
                                           input logic [TCNT_MAX_W-1:0] term,
                                           input logic en);
    return en && (cur == term);
  endfunction

endpackage

// File: rtl/tcnt_stage.sv
module tcnt_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_en,
  input  logic clr,
  output logic q
);

  logic d_next;

  // D register plus XOR: toggle when tog_en is 1, hold when 0; clear wins.
  always_comb begin
    if (clr) d_next = 1'b0;
    else     d_next = q ^ tog_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_next;
  end

  // R8: without enable and without clear the stage holds.
  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en && !clr) |=> $stable(q));

endmodule

// File: rtl/tcnt_carry_chain.sv
module tcnt_carry_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             en,
  input  logic [WIDTH-1:0] bits,
  output logic [WIDTH-1:0] tog
);

  assign tog[0] = en;

  genvar gi;
  generate
    for (gi = 1; gi < WIDTH; gi++) begin : g_link
      assign tog[gi] = tog[gi-1] & bits[gi-1];
    end
  endgenerate

  // Top bit's carry-out is intentionally not needed: all-ones wraps naturally.
  logic unused_msb;
  assign unused_msb = bits[WIDTH-1];

endmodule

// File: rtl/tcnt_term_detect.sv
module tcnt_term_detect
  import tcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] term,
  input  logic             en,
  output logic             hit
);

  assign hit = tcnt_term_match(TCNT_MAX_W'(cur), TCNT_MAX_W'(term), en);

endmodule

// File: rtl/tcnt_modulo_counter.sv
module tcnt_modulo_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] term_val,
  output logic [WIDTH-1:0] count,
  output logic             term_hit
);

  logic [WIDTH-1:0] tog_vec;   // per-stage toggle enables
  logic             clr_req;   // synchronous clear request, one full period

  tcnt_carry_chain #(.WIDTH(WIDTH)) i_chain (
    .en   (cnt_en),
    .bits (count),
    .tog  (tog_vec)
  );

  tcnt_term_detect #(.WIDTH(WIDTH)) i_detect (
    .cur  (count),
    .term (term_val),
    .en   (cnt_en),
    .hit  (clr_req)
  );

  genvar gb;
  generate
    for (gb = 0; gb < WIDTH; gb++) begin : g_bit
      tcnt_stage i_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog_en (tog_vec[gb]),
        .clr    (clr_req),
        .q      (count[gb])
      );
    end
  endgenerate

  assign term_hit = clr_req;

  // R3: a clear request leads to zero on the next edge.
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (count == '0));

  // R2: away from the terminal, an enabled edge adds one.
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !clr_req) |=> (count == WIDTH'($past(count) + 1'b1)));

  // R4: disabled edges hold the count.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  // R5: the flag is never raised while counting is disabled.
  a_r5_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |-> cnt_en);

endmodule

// File: tb/test_tcnt_modulo_counter.sv
module test_tcnt_modulo_counter;

  localparam int W = 4;
  localparam int MODV = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [W-1:0] term_val = 4'd9;
  logic [W-1:0] count;
  logic         term_hit;

  int checks = 0;
  int fails = 0;
  int ref_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tcnt_modulo_counter #(.WIDTH(W)) i_tcnt_modulo_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .term_val(term_val),
    .count(count), .term_hit(term_hit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: apply inputs, advance the model at the edge, compare after it.
  task automatic step(input bit en, input int tv, input string req);
    int prev;
    cnt_en = en;
    term_val = W'(tv);
    @(posedge clk);
    prev = ref_cnt;
    if (en) begin
      if (ref_cnt == tv) ref_cnt = 0;
      else               ref_cnt = (ref_cnt + 1) % MODV;
    end
    @(negedge clk);
    check(count == W'(ref_cnt), req, count, ref_cnt);
    check(term_hit == (en && ref_cnt == tv), "R5", term_hit, (en && ref_cnt == tv));
    if (prev == 7 && en && tv != 7)
      check(count == 4'd8, "R8", count, 8);
    if (tv == 9)
      check(count != 4'd10, "R3", count, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #5;
    check(count == 0, "R1", count, 0);
    check(term_hit == 1'b0, "R5", term_hit, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3: decade sequence, several wraps
    for (int k = 0; k < 25; k++) begin
      step(1'b1, 9, (ref_cnt == 9) ? "R3" : "R2");
    end

    // R4: hold mid-count
    for (int k = 0; k < 4; k++) step(1'b0, 9, "R4");
    // run up to the terminal value and freeze on it
    while (ref_cnt != 9) step(1'b1, 9, "R2");
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 9, "R4");
      check(term_hit == 1'b0, "R4", term_hit, 0);
    end
    step(1'b1, 9, "R3");

    // R6: other terminal values
    for (int k = 0; k < 10; k++) step(1'b1, 3, "R6");
    for (int k = 0; k < 20; k++) step(1'b1, 15, "R6");
    for (int k = 0; k < 8; k++) step(1'b1, 0, "R6");

    // R7: park at 12 with terminal 15, then lower the terminal to 5
    while (ref_cnt != 12) step(1'b1, 15, "R2");
    for (int k = 0; k < 4; k++) step(1'b1, 5, "R7");
    check(count == 0, "R7", count, 0);
    for (int k = 0; k < 14; k++) step(1'b1, 5, "R7");

    // R1: asynchronous reset in the middle of a cycle
    while (ref_cnt != 6) step(1'b1, 9, "R2");
    #3 rst_n = 1'b0;
    #2;
    check(count == 0, "R1", count, 0);
    ref_cnt = 0;
    @(negedge clk);
    check(count == 0, "R1", count, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) step(1'b1, 9, (ref_cnt == 9) ? "R3" : "R2");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule